// File: doc/BRIEF.md
# Open-Drain Soft Reset Sequencer

This block runs the soft reset pin of a processor subsystem. The pin is shared and open-drain. The block can only pull it low, and an external pull-up brings it back high. A soft reset starts in one of two ways. Another device can pull the pin low, which the block sees through a synchronizer. Or a request can arrive on the JTAG soft reset line or the debug-port soft reset line.

Once a sequence starts, the block holds the pin low for a fixed window. In the last cycle of that window it captures the two debug configuration inputs and then releases the pin. It then waits, with no time limit, until the pin reads high again. At that point it sends a one-cycle pulse on one of two outputs. If the debug clock input is high at that moment the pulse goes to debug entry; otherwise it goes to fetch the reset vector. A guard interval follows, during which the pin is ignored, so the block does not take its own release as a new external reset.

Top module: `srst_seq`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it, `pin_drive_o`, `busy_o`, `cfg_di_o`, `cfg_ck_o`, `debug_entry_o` and `fetch_vector_o` are all 0.
- R2: When the block is idle, a high level on `jtag_srst_i` or `dbg_srst_req_i` at a clock edge makes `pin_drive_o` go high after that same edge.
- R3: When the block is idle and `pin_level_i` goes low, `pin_drive_o` goes high after the third clock edge that samples the low level. Two of those edges are the synchronizer stages.
- R4: `pin_drive_o` stays high for exactly DRIVE_CYCLES consecutive cycles (512 by default) in each sequence.
- R5: At the edge that ends the drive window, `cfg_di_o` and `cfg_ck_o` take the values on `cfg_di_i` and `cfg_ck_i`. They change at no other edge except the asynchronous clear.
- R6: After the pin is released, no result pulse appears while `pin_level_i` is held low, however long that lasts, and `busy_o` stays high.
- R7: Each sequence gives exactly one single-cycle result pulse, in the third cycle after `pin_level_i` returns high. The pulse goes to `debug_entry_o` if `cfg_ck_i` is 1 at that point and to `fetch_vector_o` if it is 0. The two outputs are never high together.
- R8: `busy_o` stays high for GUARD_CYCLES cycles (16 by default), counting from the cycle of the result pulse. A low `pin_level_i` during this interval does not start a new sequence.
- R9: Requests on `jtag_srst_i` or `dbg_srst_req_i` that arrive while `busy_o` is high are dropped. They are not queued and do not lengthen the current sequence.
- R10: `busy_o` is high from the first drive cycle until the guard interval ends, and `pin_drive_o` is never high without `busy_o`.
- R11: Pulling `rst_ni` low during a sequence at once releases the pin, clears `busy_o` and clears the captured configuration. After `rst_ni` returns high with the pin high, the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hard reset |
| pin_level_i | input | 1 | Raw level read back from the soft reset pin |
| jtag_srst_i | input | 1 | JTAG soft reset request |
| dbg_srst_req_i | input | 1 | Debug-port soft reset request |
| cfg_di_i | input | 1 | Debug data-in configuration input |
| cfg_ck_i | input | 1 | Debug clock configuration input; also selects the result |
| pin_drive_o | output | 1 | 1 = pull the pin low |
| busy_o | output | 1 | A sequence or the guard interval is in progress |
| cfg_di_o | output | 1 | Captured data-in configuration |
| cfg_ck_o | output | 1 | Captured clock configuration |
| debug_entry_o | output | 1 | One-cycle pulse: enter debug mode |
| fetch_vector_o | output | 1 | One-cycle pulse: fetch the reset vector |

## Verification
A wrong count in the shared counter shows up at the ports right away. The drive window is one or more cycles too long or too short, or the guard interval ends early or late, or `busy_o` is still high when the next trigger arrives. A wrong controller state shows up within a few cycles, as one of these:
- a pulse during the drive window;
- a missing pulse after the pin returns high;
- a second sequence starting right after the guard interval.

A faulty capture path shows up on `cfg_di_o` and `cfg_ck_o` as soon as the drive window ends. The sweep uses every trigger source with every configuration pair, so each of these faults shows up in at least one run.

// File: rtl/srst_pkg.sv
package srst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRIVE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_GUARD = 2'd3
  } srst_state_e;
endpackage

// File: rtl/srst_sync.sv
module srst_sync #(
  parameter int  STAGES  = 2,
  parameter bit  RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q[i] <= RST_VAL;
      else if (i == 0) ff_q[i] <= d_i;
      else ff_q[i] <= ff_q[(i > 0) ? i-1 : 0];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/srst_cnt.sv
module srst_cnt #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         en_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (load_i)             cnt_q <= load_val_i;
    else if (en_i && !zero_o)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/srst_ctrl.sv
module srst_ctrl
  import srst_pkg::*;
#(
  parameter int W            = 9,
  parameter int DRIVE_CYCLES = 512,
  parameter int GUARD_CYCLES = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pin_sync_i,
  input  logic         req_i,
  input  logic         cnt_zero_i,
  input  logic         cfg_ck_i,
  output srst_state_e  state_o,
  output logic         cnt_load_o,
  output logic [W-1:0] cnt_val_o,
  output logic         cnt_en_o,
  output logic         latch_o,
  output logic         dbg_pulse_o,
  output logic         fetch_pulse_o
);
  localparam logic [W-1:0] DRIVE_LD = W'(DRIVE_CYCLES - 1);
  localparam logic [W-1:0] GUARD_LD = W'(GUARD_CYCLES - 1);

  srst_state_e state_q, state_d;
  logic        dbg_q, fetch_q, release_seen;

  always_comb begin
    state_d    = state_q;
    cnt_load_o = 1'b0;
    cnt_val_o  = DRIVE_LD;
    cnt_en_o   = 1'b0;
    latch_o    = 1'b0;
    release_seen = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        // external low or internal request both start a sequence
        if (req_i || !pin_sync_i) begin
          state_d    = ST_DRIVE;
          cnt_load_o = 1'b1;
          cnt_val_o  = DRIVE_LD;
        end
      end
      ST_DRIVE: begin
        cnt_en_o = 1'b1;
        if (cnt_zero_i) begin
          state_d = ST_WAIT;
          latch_o = 1'b1;
        end
      end
      ST_WAIT: begin
        if (pin_sync_i) begin
          state_d      = ST_GUARD;
          cnt_load_o   = 1'b1;
          cnt_val_o    = GUARD_LD;
          release_seen = 1'b1;
        end
      end
      ST_GUARD: begin
        cnt_en_o = 1'b1;
        if (cnt_zero_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dbg_q   <= 1'b0;
      fetch_q <= 1'b0;
    end else begin
      state_q <= state_d;
      dbg_q   <= release_seen &&  cfg_ck_i;
      fetch_q <= release_seen && !cfg_ck_i;
    end
  end

  assign state_o       = state_q;
  assign dbg_pulse_o   = dbg_q;
  assign fetch_pulse_o = fetch_q;
endmodule

// File: rtl/srst_seq.sv
module srst_seq
  import srst_pkg::*;
#(
  parameter int DRIVE_CYCLES = 512,
  parameter int GUARD_CYCLES = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_level_i,
  input  logic jtag_srst_i,
  input  logic dbg_srst_req_i,
  input  logic cfg_di_i,
  input  logic cfg_ck_i,
  output logic pin_drive_o,
  output logic busy_o,
  output logic cfg_di_o,
  output logic cfg_ck_o,
  output logic debug_entry_o,
  output logic fetch_vector_o
);
  localparam int MAX_CYC = (DRIVE_CYCLES > GUARD_CYCLES) ? DRIVE_CYCLES : GUARD_CYCLES;
  localparam int CNT_W   = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;

  srst_state_e    state;
  logic           pin_sync, cnt_load, cnt_en, cnt_zero, latch;
  logic [CNT_W-1:0] cnt_val;
  logic           cfg_di_q, cfg_ck_q;

  // pin idles high, so the synchronizer resets to 1
  srst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_level_i),
    .q_o   (pin_sync)
  );

  srst_cnt #(.W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (cnt_load),
    .load_val_i(cnt_val),
    .en_i      (cnt_en),
    .zero_o    (cnt_zero)
  );

  srst_ctrl #(
    .W           (CNT_W),
    .DRIVE_CYCLES(DRIVE_CYCLES),
    .GUARD_CYCLES(GUARD_CYCLES)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pin_sync_i   (pin_sync),
    .req_i        (jtag_srst_i | dbg_srst_req_i),
    .cnt_zero_i   (cnt_zero),
    .cfg_ck_i     (cfg_ck_i),
    .state_o      (state),
    .cnt_load_o   (cnt_load),
    .cnt_val_o    (cnt_val),
    .cnt_en_o     (cnt_en),
    .latch_o      (latch),
    .dbg_pulse_o  (debug_entry_o),
    .fetch_pulse_o(fetch_vector_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_di_q <= 1'b0;
      cfg_ck_q <= 1'b0;
    end else if (latch) begin
      cfg_di_q <= cfg_di_i;
      cfg_ck_q <= cfg_ck_i;
    end
  end

  assign pin_drive_o = (state == ST_DRIVE);
  assign busy_o      = (state != ST_IDLE);
  assign cfg_di_o    = cfg_di_q;
  assign cfg_ck_o    = cfg_ck_q;
endmodule

// File: rtl/srst_seq_chk.sv
module srst_seq_chk #(
  parameter int DRIVE_CYCLES = 512
) (
  input logic clk_i,
  input logic rst_ni,
  input logic jtag_srst_i,
  input logic dbg_srst_req_i,
  input logic pin_drive_o,
  input logic busy_o,
  input logic cfg_di_o,
  input logic cfg_ck_o,
  input logic debug_entry_o,
  input logic fetch_vector_o
);
  localparam int DW = $clog2(DRIVE_CYCLES + 1) + 1;
  logic [DW-1:0] drv_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          drv_run <= '0;
    else if (pin_drive_o) drv_run <= drv_run + 1'b1;
    else                  drv_run <= '0;
  end

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (jtag_srst_i || dbg_srst_req_i)) |=> pin_drive_o);

  p_drive_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pin_drive_o) |-> (drv_run == DW'(DRIVE_CYCLES)));

  p_drive_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_run <= DW'(DRIVE_CYCLES));

  p_cfg_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(pin_drive_o) |-> ($stable(cfg_di_o) && $stable(cfg_ck_o)));

  p_result_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(debug_entry_o && fetch_vector_o));

  p_result_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (debug_entry_o || fetch_vector_o) |=> !(debug_entry_o || fetch_vector_o));

  p_result_ctx_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (debug_entry_o || fetch_vector_o) |-> (busy_o && !pin_drive_o));

  p_drive_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_drive_o |-> busy_o);

  p_release_wait_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pin_drive_o) |-> busy_o);
endmodule

bind srst_seq srst_seq_chk #(.DRIVE_CYCLES(DRIVE_CYCLES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .jtag_srst_i   (jtag_srst_i),
  .dbg_srst_req_i(dbg_srst_req_i),
  .pin_drive_o   (pin_drive_o),
  .busy_o        (busy_o),
  .cfg_di_o      (cfg_di_o),
  .cfg_ck_o      (cfg_ck_o),
  .debug_entry_o (debug_entry_o),
  .fetch_vector_o(fetch_vector_o)
);

// File: tb/sim_srst_seq.sv
`timescale 1ns/1ps
module sim_srst_seq;
  localparam int DRV = 512;
  localparam int GRD = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic jtag = 1'b0, dreq = 1'b0, ext_low = 1'b0;
  logic cfg_di = 1'b0, cfg_ck = 1'b0;
  logic pin_level;
  logic pin_drive_o, busy_o, cfg_di_o, cfg_ck_o, debug_entry_o, fetch_vector_o;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  // open-drain pin with external pull-up
  assign pin_level = !(pin_drive_o || ext_low);

  srst_seq #(.DRIVE_CYCLES(DRV), .GUARD_CYCLES(GRD), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pin_level_i(pin_level),
    .jtag_srst_i(jtag), .dbg_srst_req_i(dreq),
    .cfg_di_i(cfg_di), .cfg_ck_i(cfg_ck),
    .pin_drive_o(pin_drive_o), .busy_o(busy_o),
    .cfg_di_o(cfg_di_o), .cfg_ck_o(cfg_ck_o),
    .debug_entry_o(debug_entry_o), .fetch_vector_o(fetch_vector_o)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic quiet_idle(input string tag, input int n);
    int seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (pin_drive_o || busy_o) seen++;
    end
    chk(tag, seen, 0);
  endtask

  // src: 0 jtag, 1 debug request, 2 external low
  task automatic run_seq(input int src, input bit di, input bit ck, input bit poke);
    int lat, len, dly, pulses, gl, nobusy;
    bit dbg_seen;
    cfg_di = di;
    cfg_ck = ck;
    case (src)
      0: jtag = 1'b1;
      1: dreq = 1'b1;
      default: ext_low = 1'b1;
    endcase
    lat = 0;
    do begin step(); lat++; end while (!pin_drive_o && lat < 10);
    jtag = 1'b0; dreq = 1'b0; ext_low = 1'b0;
    if (src == 2) chk("R3 start latency", lat, 3);
    else          chk("R2 start latency", lat, 1);
    len = 0; nobusy = 0;
    while (pin_drive_o && len < DRV + 50) begin
      len++;
      if (!busy_o) nobusy++;
      if (poke && len == 100) begin dreq = 1'b1; jtag = 1'b1; end
      else begin dreq = 1'b0; jtag = 1'b0; end
      step();
    end
    chk("R4 drive length", len, DRV);
    chk("R10 busy during drive", nobusy, 0);
    chk("R5 cfg_di capture", int'(cfg_di_o), int'(di));
    chk("R5 cfg_ck capture", int'(cfg_ck_o), int'(ck));
    dly = 0;
    while (!(debug_entry_o || fetch_vector_o) && dly < 20) begin step(); dly++; end
    chk("R7 result delay", dly, 3);
    chk("R7 result select", int'(debug_entry_o), int'(ck));
    dbg_seen = debug_entry_o;
    gl = 0; pulses = 0;
    while (busy_o && gl < 100) begin
      if (debug_entry_o || fetch_vector_o) pulses++;
      if (debug_entry_o && fetch_vector_o) pulses += 10;
      gl++;
      step();
    end
    chk("R7 single pulse", pulses, 1);
    chk("R8 guard length", gl, GRD);
    if (dbg_seen != ck) chk("R7 pulse kind", int'(dbg_seen), int'(ck));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int gl, hold_bad;
    #2;
    // R1 during reset
    chk("R1 drive in reset", int'(pin_drive_o), 0);
    chk("R1 busy in reset", int'(busy_o), 0);
    chk("R1 cfg in reset", int'(cfg_di_o) + int'(cfg_ck_o), 0);
    chk("R1 results in reset", int'(debug_entry_o) + int'(fetch_vector_o), 0);
    step(); step();
    rst_ni = 1'b1;
    step();
    chk("R1 idle after reset", int'(busy_o) + int'(pin_drive_o), 0);
    quiet_idle("R1 stays idle", 8);

    // exhaustive sweep: sources x configuration pairs
    for (int s = 0; s < 3; s++)
      for (int c = 0; c < 4; c++) begin
        run_seq(s, c[1], c[0], 1'b0);
        step(); step();
      end

    // R9: requests during drive are dropped
    run_seq(0, 1'b0, 1'b0, 1'b1);
    quiet_idle("R9 request not queued", 30);

    // R8: low pin during guard ignored
    cfg_ck = 1'b0;
    jtag = 1'b1; step(); jtag = 1'b0;
    while (pin_drive_o) step();
    while (!(debug_entry_o || fetch_vector_o)) step();
    ext_low = 1'b1;
    gl = 0;
    while (busy_o && gl < 100) begin
      gl++;
      if (gl == 4) ext_low = 1'b0;
      step();
    end
    chk("R8 guard with pin low", gl, GRD);
    quiet_idle("R8 no retrigger", 30);

    // R6: pin held low after release, then R7 uses live cfg_ck
    cfg_di = 1'b1; cfg_ck = 1'b0;
    dreq = 1'b1; step(); dreq = 1'b0;
    while (pin_drive_o) step();
    ext_low = 1'b1;
    chk("R5 cfg_ck latched low", int'(cfg_ck_o), 0);
    hold_bad = 0;
    for (int i = 0; i < 60; i++) begin
      step();
      if (debug_entry_o || fetch_vector_o || !busy_o || pin_drive_o) hold_bad++;
      if (i == 30) cfg_ck = 1'b1;
    end
    chk("R6 wait while pin low", hold_bad, 0);
    ext_low = 1'b0;
    step(); step(); step();
    chk("R7 debug entry from live clock pin", int'(debug_entry_o), 1);
    chk("R7 no fetch pulse", int'(fetch_vector_o), 0);
    while (busy_o) step();

    // R11: hard reset mid-drive with configuration previously captured as 1
    run_seq(1, 1'b1, 1'b1, 1'b0);
    chk("R11 cfg set before reset", int'(cfg_di_o) + int'(cfg_ck_o), 2);
    jtag = 1'b1; step(); jtag = 1'b0;
    for (int i = 0; i < 50; i++) step();
    #2 rst_ni = 1'b0;
    #1;
    chk("R11 drive released", int'(pin_drive_o), 0);
    chk("R11 busy cleared", int'(busy_o), 0);
    chk("R11 cfg cleared", int'(cfg_di_o) + int'(cfg_ck_o), 0);
    step(); step();
    #2 rst_ni = 1'b1;
    quiet_idle("R11 idle after reset", 20);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule